// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block holds a small set of decode windows, each of which maps one region of the physical address space onto one DRAM chip select. Software programs every window through a 32-bit register port. For each lookup the block returns whether the address falls in an enabled window, which chip select serves it, and an attribute byte for that rank. The attribute byte is a one-cold nibble that marks the chosen window, and a hardware-coherency flag can be merged into it.

A compile-time parameter picks between two register formats. The default format has four windows with separate base and size registers, and it covers a 36-bit physical address. The compact format has two windows. Each compact window packs enable, base and a logarithmic size code into a single register, and its attribute output is always zero.

Lookups are pipelined with a latency of one cycle. A lookup can be flagged as coming from a 32-bit device master. Such a lookup never matches a window that lies above 4 GB.

Top module: `dcs_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads zero, and `res_vld`, `res_hit`, `res_cs` and `res_attr` are zero.
- R2: The default format uses these registers for window n. The base register is at offset 8·n and holds address bits 31:24 in bits 31:24 and address bits 35:32 in bits 3:0. The size register is at offset 8·n+4 and holds enable in bit 0, the chip-select number in bits 4:2, and (size/16 MB − 1) in bits 31:24. Bits outside these fields read zero. A write to any other offset changes no register.
- R3: In the default format, an address hits window n when all of the following hold: the window is enabled; address bits 35:32 equal the high base field; and address bits 31:24, with the size field's set bits cleared, equal the base field. Address bits 23:0 are ignored.
- R4: When several windows hit, the lowest-numbered window decides the result.
- R5: In the default format, on a hit `res_cs` carries the chip-select field (bits 4:2) of the winning window's size register.
- R6: In the default format, on a hit `res_attr[3:0]` is 4'hF with bit n cleared, where n is the winning window. `res_attr[4]` equals the `coh_en` value sampled with the lookup, and `res_attr[7:5]` is zero.
- R7: When `look_narrow` is 1, a window with a nonzero high base field never hits. A lower-priority window may then supply the result.
- R8: On a miss, `res_hit`, `res_cs` and `res_attr` are all zero.
- R9: The result of a lookup presented with `look_vld`=1 appears on the next cycle with `res_vld`=1. A cycle with `look_vld`=0 is followed by a cycle in which all four result outputs are zero.
- R10: The compact format (`COMPACT`=1) has two windows, one register each at offset 16·n. Bit 0 is enable, bits 31:23 hold address bits 31:23 of the base, and bits 19:16 hold a size code c. The window size is 2^(16+c) bytes, which is 1 MB shifted left by (c−4). An address hits when the window is enabled, address bits 35:32 are zero, and the address with its low 16+c bits cleared equals the base. Other register bits read zero.
- R11: In the compact format, `res_cs` on a hit is the winning window's number and `res_attr` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| look_vld | input | 1 | Lookup request valid |
| look_addr | input | 36 | Physical address to decode |
| look_narrow | input | 1 | Request comes from a 32-bit master |
| coh_en | input | 1 | Hardware coherency active, merged into the attribute |
| res_vld | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Address fell in an enabled window |
| res_cs | output | 3 | Chip-select index of the winning window |
| res_attr | output | 8 | Attribute byte for the winning rank |

## Verification
The bench builds two instances side by side. One uses `COMPACT`=0, so that four windows, high base bits, the narrow-master filter, the one-cold attribute and the coherency bit can all be reached. The other uses `COMPACT`=1, which brings the logarithmic size code, the two-window register layout and the zero attribute within reach. Both instances share the lookup inputs, so every address is judged by both formats in the same cycle. Directed cases cover overlapping windows, window edges, and writes to unmapped offsets.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int PA_W   = 36;
    localparam int CS_W   = 3;
    localparam int ATTR_W = 8;
    localparam int REG_W  = 32;
    localparam int OFF_W  = 8;
    localparam int NIB_W  = 4;
    localparam logic [REG_W-1:0] STD_BASE_MASK = 32'hFF00_000F;
    localparam logic [REG_W-1:0] STD_SIZE_MASK = 32'hFF00_001D;
    localparam logic [REG_W-1:0] CMP_MASK      = 32'hFF8F_0001;
    localparam logic [ATTR_W-1:0] COH_BIT      = 8'h10;

    typedef struct packed {
        logic              en;
        logic              far;
        logic [PA_W-1:0]   base;
        logic [PA_W-1:0]   care;
        logic [CS_W-1:0]   cs;
        logic [ATTR_W-1:0] attr;
    } win_cfg_t;

    function automatic logic [ATTR_W-1:0] cold_nibble(input int idx);
        logic [NIB_W-1:0] n;
        n = ~(NIB_W'(1) << idx);
        return {{(ATTR_W-NIB_W){1'b0}}, n};
    endfunction
endpackage

// File: rtl/dcs_regfile.sv
module dcs_regfile
    import dcs_pkg::*;
#(
    parameter int COMPACT = 0,
    parameter int NWIN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFF_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output win_cfg_t         cfg_o [NWIN]
);
    logic [REG_W-1:0] rd_w [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        if (COMPACT == 0) begin : g_std
            localparam logic [OFF_W-1:0] BOFF = OFF_W'(8 * g);
            localparam logic [OFF_W-1:0] SOFF = OFF_W'(8 * g + 4);
            logic [REG_W-1:0] base_q;
            logic [REG_W-1:0] size_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_q <= '0;
                    size_q <= '0;
                end else if (we) begin
                    if (addr == BOFF) base_q <= wdata & STD_BASE_MASK;
                    if (addr == SOFF) size_q <= wdata & STD_SIZE_MASK;
                end
            end

            always_comb begin
                cfg_o[g].en   = size_q[0];
                cfg_o[g].far  = |base_q[3:0];
                cfg_o[g].base = {base_q[3:0], base_q[31:24], 24'h0};
                cfg_o[g].care = {4'hF, ~size_q[31:24], 24'h0};
                cfg_o[g].cs   = size_q[4:2];
                cfg_o[g].attr = cold_nibble(g);
                if (addr == BOFF)      rd_w[g] = base_q;
                else if (addr == SOFF) rd_w[g] = size_q;
                else                   rd_w[g] = '0;
            end
        end else begin : g_cmp
            localparam logic [OFF_W-1:0] WOFF = OFF_W'(16 * g);
            logic [REG_W-1:0] word_q;
            logic [PA_W-1:0]  low_span;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                   word_q <= '0;
                else if (we && addr == WOFF)  word_q <= wdata & CMP_MASK;
            end

            always_comb begin
                low_span      = (PA_W'(1) << (16 + int'(word_q[19:16]))) - PA_W'(1);
                cfg_o[g].en   = word_q[0];
                cfg_o[g].far  = 1'b0;
                cfg_o[g].base = {4'h0, word_q[31:23], 23'h0};
                cfg_o[g].care = ~low_span;
                cfg_o[g].cs   = CS_W'(g);
                cfg_o[g].attr = '0;
                rd_w[g]       = (addr == WOFF) ? word_q : '0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NWIN; i++) rdata = rdata | rd_w[i];
    end
endmodule

// File: rtl/dcs_win_match.sv
module dcs_win_match
    import dcs_pkg::*;
(
    input  logic            en,
    input  logic            far,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] care,
    input  logic [PA_W-1:0] addr,
    input  logic            narrow,
    output logic            hit
);
    always_comb begin
        hit = en && !(narrow && far) && ((addr & care) == base);
    end
endmodule

// File: rtl/dcs_pick.sv
module dcs_pick
    import dcs_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic [NWIN-1:0]   hits,
    input  logic [CS_W-1:0]   cs_in   [NWIN],
    input  logic [ATTR_W-1:0] attr_in [NWIN],
    output logic              hit,
    output logic [CS_W-1:0]   cs,
    output logic [ATTR_W-1:0] attr
);
    always_comb begin
        hit  = 1'b0;
        cs   = '0;
        attr = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (hits[i] && !hit) begin
                hit  = 1'b1;
                cs   = cs_in[i];
                attr = attr_in[i];
            end
        end
    end
endmodule

// File: rtl/dcs_decoder.sv
module dcs_decoder
    import dcs_pkg::*;
#(
    parameter int COMPACT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              look_vld,
    input  logic [PA_W-1:0]   look_addr,
    input  logic              look_narrow,
    input  logic              coh_en,
    output logic              res_vld,
    output logic              res_hit,
    output logic [CS_W-1:0]   res_cs,
    output logic [ATTR_W-1:0] res_attr
);
    localparam int NWIN = (COMPACT != 0) ? 2 : 4;

    win_cfg_t          cfg [NWIN];
    logic [NWIN-1:0]   hits;
    logic [CS_W-1:0]   cs_arr   [NWIN];
    logic [ATTR_W-1:0] attr_arr [NWIN];
    logic              p_hit;
    logic [CS_W-1:0]   p_cs;
    logic [ATTR_W-1:0] p_attr;
    logic [ATTR_W-1:0] coh_or;

    dcs_regfile #(.COMPACT(COMPACT), .NWIN(NWIN)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg_o (cfg)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_match
        dcs_win_match match_i (
            .en     (cfg[g].en),
            .far    (cfg[g].far),
            .base   (cfg[g].base),
            .care   (cfg[g].care),
            .addr   (look_addr),
            .narrow (look_narrow),
            .hit    (hits[g])
        );
        assign cs_arr[g]   = cfg[g].cs;
        assign attr_arr[g] = cfg[g].attr;
    end

    dcs_pick #(.NWIN(NWIN)) pick_i (
        .hits    (hits),
        .cs_in   (cs_arr),
        .attr_in (attr_arr),
        .hit     (p_hit),
        .cs      (p_cs),
        .attr    (p_attr)
    );

    assign coh_or = (COMPACT == 0 && coh_en && p_hit) ? COH_BIT : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_hit  <= 1'b0;
            res_cs   <= '0;
            res_attr <= '0;
        end else begin
            res_vld  <= look_vld;
            res_hit  <= look_vld && p_hit;
            res_cs   <= look_vld ? p_cs : '0;
            res_attr <= look_vld ? (p_attr | coh_or) : '0;
        end
    end
endmodule

// File: rtl/dcs_decoder_chk.sv
module dcs_decoder_chk
    import dcs_pkg::*;
#(
    parameter int COMPACT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              look_vld,
    input logic [3:0]        look_hi,
    input logic              look_narrow,
    input logic              coh_en,
    input logic              res_vld,
    input logic              res_hit,
    input logic [CS_W-1:0]   res_cs,
    input logic [ATTR_W-1:0] res_attr
);
    assert_vld_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        look_vld |=> res_vld);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !look_vld |=> (!res_vld && !res_hit && res_cs == '0 && res_attr == '0));

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_cs == '0 && res_attr == '0));

    assert_narrow_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (look_vld && look_narrow) |=> (!res_hit || $past(look_hi) == 4'h0));

    if (COMPACT == 0) begin : g_std
        assert_attr_cold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            res_hit |-> ($countones(res_attr[3:0]) == 3 && res_attr[7:5] == 3'b0));

        assert_coh_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            look_vld |=> (res_attr[4] == ($past(coh_en) && res_hit)));
    end else begin : g_cmp
        assert_attr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
            res_attr == '0);

        assert_cs_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
            res_cs[2:1] == 2'b00);
    end
endmodule

bind dcs_decoder dcs_decoder_chk #(.COMPACT(COMPACT)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .look_vld    (look_vld),
    .look_hi     (look_addr[35:32]),
    .look_narrow (look_narrow),
    .coh_en      (coh_en),
    .res_vld     (res_vld),
    .res_hit     (res_hit),
    .res_cs      (res_cs),
    .res_attr    (res_attr)
);

// File: tb/dcs_decoder_tb.sv
module dcs_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_d = 1'b0, we_c = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_d, rd_c;
    logic        look_vld = 1'b0, look_narrow = 1'b0, coh_en = 1'b0;
    logic [35:0] look_addr = '0;
    logic        d_vld, d_hit, c_vld, c_hit;
    logic [2:0]  d_cs, c_cs;
    logic [7:0]  d_attr, c_attr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] sd_b [4];
    logic [31:0] sd_s [4];
    logic [31:0] sc   [2];

    always #2 clk = ~clk;

    dcs_decoder #(.COMPACT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(we_d), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_d), .look_vld(look_vld),
        .look_addr(look_addr), .look_narrow(look_narrow), .coh_en(coh_en),
        .res_vld(d_vld), .res_hit(d_hit), .res_cs(d_cs), .res_attr(d_attr));

    dcs_decoder #(.COMPACT(1)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .reg_we(we_c), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_c), .look_vld(look_vld),
        .look_addr(look_addr), .look_narrow(look_narrow), .coh_en(coh_en),
        .res_vld(c_vld), .res_hit(c_hit), .res_cs(c_cs), .res_attr(c_attr));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {hit, cs, attr} expected for the default format (R3..R8)
    function automatic logic [11:0] exp_d(input logic [35:0] a, input logic nar, input logic coh);
        for (int i = 0; i < 4; i++) begin
            if (sd_s[i][0] && !(nar && sd_b[i][3:0] != 4'h0) && a[35:32] == sd_b[i][3:0] &&
                ((a[31:24] & ~sd_s[i][31:24]) == sd_b[i][31:24]))
                return {1'b1, sd_s[i][4:2], 3'b000, coh, 4'hF & ~(4'b0001 << i)};
        end
        return 12'h0;
    endfunction

    // {hit, cs, attr} expected for the compact format (R10, R11)
    function automatic logic [11:0] exp_c(input logic [35:0] a);
        logic [63:0] aa, lo, bs;
        aa = {28'h0, a};
        for (int i = 0; i < 2; i++) begin
            lo = (64'd1 << (16 + int'(sc[i][19:16]))) - 64'd1;
            bs = {32'h0, sc[i][31:23], 23'h0};
            if (sc[i][0] && ((aa & ~lo) == bs))
                return {1'b1, 3'(i), 8'h00};
        end
        return 12'h0;
    endfunction

    task automatic wr_d(input logic [7:0] off, input logic [31:0] data);
        @(negedge clk);
        we_d = 1'b1; reg_addr = off; reg_wdata = data;
        @(negedge clk);
        we_d = 1'b0;
        if (off < 8'd32 && off[1:0] == 2'b00) begin
            if (off[2]) sd_s[off[4:3]] = data & 32'hFF00_001D;
            else        sd_b[off[4:3]] = data & 32'hFF00_000F;
        end
    endtask

    task automatic wr_c(input logic [7:0] off, input logic [31:0] data);
        @(negedge clk);
        we_c = 1'b1; reg_addr = off; reg_wdata = data;
        @(negedge clk);
        we_c = 1'b0;
        if (off == 8'd0 || off == 8'd16) sc[off[4]] = data & 32'hFF8F_0001;
    endtask

    task automatic readback(input string req);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            reg_addr = 8'(4 * k);
            #1;
            chk(req, rd_d, k[0] ? sd_s[k/2] : sd_b[k/2]);
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            reg_addr = 8'(16 * k);
            #1;
            chk(req, rd_c, sc[k]);
        end
    endtask

    task automatic look(input logic [35:0] a, input logic nar, input logic coh, input string req);
        logic [11:0] ed, ec;
        @(negedge clk);
        look_vld = 1'b1; look_addr = a; look_narrow = nar; coh_en = coh;
        ed = exp_d(a, nar, coh);
        ec = exp_c(a);
        @(negedge clk);
        chk(req, {d_vld, d_hit, d_cs, d_attr}, {1'b1, ed});
        chk(req, {c_vld, c_hit, c_cs, c_attr}, {1'b1, ec});
        look_vld = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4; i++) begin sd_b[i] = '0; sd_s[i] = '0; end
        for (int i = 0; i < 2; i++) sc[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {d_vld, d_hit, d_cs, d_attr, c_vld, c_hit, c_cs, c_attr}, 0);
        rst_n = 1'b1;
        readback("R1 regs zero");
        look(36'h0_0000_0000, 1'b0, 1'b0, "R1 all disabled");

        // R2: field layout, undefined bits, unmapped offsets
        wr_d(8'h18, 32'hFFFF_FFFF);
        wr_d(8'h1C, 32'hFFFF_FFFF);
        wr_d(8'h02, 32'hFFFF_FFFF);
        wr_d(8'h40, 32'hFFFF_FFFF);
        wr_d(8'h21, 32'hFFFF_FFFF);
        readback("R2 layout");
        wr_d(8'h18, 32'h0); wr_d(8'h1C, 32'h0);

        // R3, R5, R6: window 0 at 256 MB, 32 MB, chip select 2
        wr_d(8'h00, 32'h1000_0000);
        wr_d(8'h04, 32'h0100_0009);
        look(36'h0_11FF_FFFF, 1'b0, 1'b0, "R3 last byte R5 R6");
        look(36'h0_1200_0000, 1'b0, 1'b0, "R3 just past end R8");
        look(36'h0_0FFF_FFFF, 1'b0, 1'b0, "R3 just below base R8");
        look(36'h1_1000_0000, 1'b0, 1'b0, "R3 high bits differ R8");

        // R4: overlap, lowest index wins
        wr_d(8'h08, 32'h1000_0000);
        wr_d(8'h0C, 32'h0000_0015);
        look(36'h0_1000_0040, 1'b0, 1'b0, "R4 overlap window0");
        wr_d(8'h04, 32'h0);
        look(36'h0_1000_0040, 1'b0, 1'b1, "R4 window1 R6 coherency");

        // R7: window above 4 GB
        wr_d(8'h10, 32'h0000_0003);
        wr_d(8'h14, 32'h0000_0001);
        look(36'h3_0000_1234, 1'b0, 1'b1, "R7 wide master hits");
        look(36'h3_0000_1234, 1'b1, 1'b1, "R7 narrow master misses");

        // R9: idle cycle clears results
        @(negedge clk);
        look_vld = 1'b0; look_addr = 36'h3_0000_1234;
        @(negedge clk);
        chk("R9 idle", {d_vld, d_hit, d_cs, d_attr, c_vld, c_hit, c_cs, c_attr}, 0);

        // R10, R11: compact window 0 at 8 MB, 1 MB
        wr_c(8'h00, 32'h0084_0001);
        look(36'h0_008F_FFFF, 1'b0, 1'b1, "R10 last byte R11");
        look(36'h0_0090_0000, 1'b0, 1'b0, "R10 past end");
        wr_c(8'h10, 32'hFFFF_FFFF);
        wr_c(8'h08, 32'hFFFF_FFFF);
        readback("R10 compact fields");
        look(36'h0_FF80_0001, 1'b0, 1'b0, "R10 misaligned base R11");
        wr_c(8'h10, 32'h0807_0001);
        look(36'h0_0800_FFFF, 1'b0, 1'b0, "R10 window1 R11");

        // random phase over both formats
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < 4; i++) begin
                logic [7:0] szm, bl;
                logic [3:0] hi;
                szm = 8'hFF >> ($urandom % 9);
                bl  = 8'($urandom);
                if ($urandom % 4 != 0) bl = bl & ~szm;
                hi  = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
                wr_d(8'(8 * i), {bl, 20'($urandom), hi});
                wr_d(8'(8 * i + 4), {szm, 21'($urandom), 2'($urandom), 1'($urandom % 4 != 0)});
            end
            for (int i = 0; i < 2; i++)
                wr_c(8'(16 * i), $urandom);
            for (int t = 0; t < 25; t++) begin
                logic [35:0] a;
                int w;
                w = $urandom % 4;
                case ($urandom % 3)
                    0: a = {sd_b[w][3:0], sd_b[w][31:24] | (8'($urandom) & sd_s[w][31:24]), 24'($urandom)};
                    1: a = {4'h0, sc[w % 2][31:23], 23'($urandom)};
                    default: a = 36'({$urandom, $urandom});
                endcase
                look(a, 1'($urandom), 1'($urandom), "R3 R4 R5 R6 R7 R8 R10 R11 random");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule